// File: doc/BRIEF.md
# Bus-Controlled SPI Flash Transaction Bridge

This peripheral lets a processor run one SPI transaction at a time against a serial flash or a similar device. Software fills a small word buffer with the bytes to send, such as a command, an address and dummy bytes. It then sets how many of those bytes go out and how many bytes come back, and writes to a go register. The bridge lowers chip select and clocks out the send bytes. It then clocks in the receive bytes while driving zeros. It releases chip select one SCK period after the last bit.

The received bytes land in the same buffer that held the outgoing data, packed from word 0 upward with the low byte first. Software reads them back through the ordinary buffer addresses. The bus side is a pipelined slave: every accepted access is acknowledged one cycle later. While a transfer runs, writes are held off with STALL until the transfer ends. Reads, including the status read, still complete at once.

Top module: `spi_bus_bridge`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sck` is 0, and reads of the send count (0x100), the receive count (0x101) and the status (0x102) all return 0.
- R2: A write to word address 0x100 sets the send byte count, and a write to 0x101 sets the receive byte count. A value above 2*BUF_WORDS (16 by default) is stored and read back as 16.
- R3: Any write to 0x102 starts a transfer of send+receive bytes, whatever the data. If both counts are 0, no transfer occurs and `spi_cs_n` stays 1.
- R4: A read of 0x102 returns 0xFFFF while a transfer is in progress and 0x0000 otherwise.
- R5: Buffer words sit at word addresses 0x000 to BUF_WORDS-1. Send bytes are taken in rising word order, low byte (bits 7:0) first within a word. Each byte goes out most significant bit first in SPI mode 0: SCK idles low, and MOSI is stable on every rising SCK edge.
- R6: During the receive bytes, MOSI is 0. MISO is sampled on rising SCK edges, MSB first. Receive byte j is written to buffer word j/2, in bits 7:0 for even j and bits 15:8 for odd j. Other buffer content is left unchanged.
- R7: `spi_cs_n` falls on the clock edge that accepts the go write. It stays low for exactly CLK_DIV*(8*N+1) cycles, where N is the total byte count. SCK has a period of CLK_DIV cycles and stays low whenever `spi_cs_n` is 1.
- R8: Every accepted access (`bus_stb` with `bus_stall` low) gives `bus_ack`=1 on the next cycle. `bus_stall` is 1 exactly when a write is presented during a transfer, so reads complete during a transfer.
- R9: A write held off during a transfer is accepted after the transfer ends and then takes full effect.
- R10: Reads of word addresses outside the buffer and the three registers return 0. Writes to them change no buffer word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_stb | input | 1 | Access request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 9 | Word address |
| bus_wdat | input | 16 | Write data |
| bus_rdat | output | 16 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Acknowledge, one cycle after acceptance |
| bus_stall | output | 1 | Holds off a write during a transfer |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Device select, active low |

## Verification
A send-only transfer of three bytes shows the byte order within words and the bit order on MOSI. A mixed transfer of four send and five receive bytes separates the send phase from the receive phase. It also checks the zero MOSI during reception, the write of an odd trailing byte and that neighbouring words are left alone. A receive-only transfer and an empty transfer cover the two ends of the count range. A transfer at the clamped maximum of 16+16 bytes fills every buffer word. Chip select, SCK idle and stall are compared on every clock against the window computed from the counts. A write issued during a busy transfer, followed by a read-back, shows that the write was held off and then applied.

// File: rtl/spib_pkg.sv
package spib_pkg;

  localparam logic [8:0] ADR_TX_COUNT = 9'h100;
  localparam logic [8:0] ADR_RX_COUNT = 9'h101;
  localparam logic [8:0] ADR_GO       = 9'h102;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL
  } eng_state_t;

  // limit a requested byte count to what the buffer can carry
  function automatic logic [15:0] clamp_count(input logic [15:0] req, input logic [15:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  // total bytes framed by one chip-select window
  function automatic logic [15:0] frame_bytes(input logic [15:0] n_tx, input logic [15:0] n_rx);
    return n_tx + n_rx;
  endfunction

endpackage

// File: rtl/spib_regs.sv
module spib_regs
  import spib_pkg::*;
#(
  parameter int BUF_WORDS = 8,
  parameter int CNT_W     = 5,
  parameter int BI_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             we,
  input  logic [8:0]       adr,
  input  logic [15:0]      wdat,
  output logic [15:0]      rdat,
  output logic             ack,
  output logic             stall,
  output logic             acc,
  input  logic             busy,
  output logic             go,
  output logic [CNT_W-1:0] tx_n,
  output logic [CNT_W-1:0] rx_n,
  input  logic [BI_W-1:0]  tx_idx,
  output logic [7:0]       tx_byte,
  input  logic             rx_we,
  input  logic [BI_W-1:0]  rx_idx,
  input  logic [7:0]       rx_byte
);
  localparam int WA_W      = BI_W - 1;
  localparam int MAX_BYTES = 2 * BUF_WORDS;

  logic [15:0] mem [BUF_WORDS];
  logic        wr;
  logic        in_buf;
  logic [15:0] rd_val;
  logic [15:0] tx_word;

  assign stall  = stb & we & busy;
  assign acc    = stb & ~stall;
  assign wr     = acc & we;
  assign in_buf = (adr >> WA_W) == '0;
  assign go     = wr && (adr == ADR_GO);

  assign tx_word = mem[tx_idx[BI_W-1:1]];
  assign tx_byte = tx_idx[0] ? tx_word[15:8] : tx_word[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < BUF_WORDS; w++) mem[w] <= '0;
    end else begin
      if (wr && in_buf) mem[adr[WA_W-1:0]] <= wdat;
      if (rx_we) begin
        if (rx_idx[0]) mem[rx_idx[BI_W-1:1]][15:8] <= rx_byte;
        else           mem[rx_idx[BI_W-1:1]][7:0]  <= rx_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_n <= '0;
      rx_n <= '0;
    end else if (wr) begin
      if (adr == ADR_TX_COUNT) tx_n <= CNT_W'(clamp_count(wdat, 16'(MAX_BYTES)));
      if (adr == ADR_RX_COUNT) rx_n <= CNT_W'(clamp_count(wdat, 16'(MAX_BYTES)));
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_buf) begin
      rd_val = mem[adr[WA_W-1:0]];
    end else begin
      case (adr)
        ADR_TX_COUNT: rd_val = {{(16-CNT_W){1'b0}}, tx_n};
        ADR_RX_COUNT: rd_val = {{(16-CNT_W){1'b0}}, rx_n};
        ADR_GO:       rd_val = {16{busy}};
        default:      rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack  <= 1'b0;
      rdat <= '0;
    end else begin
      ack  <= acc;
      rdat <= (acc && !we) ? rd_val : '0;
    end
  end

endmodule

// File: rtl/spib_engine.sv
module spib_engine
  import spib_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 5,
  parameter int BI_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] tx_n,
  input  logic [CNT_W-1:0] rx_n,
  output logic [BI_W-1:0]  tx_idx,
  input  logic [7:0]       tx_byte,
  output logic             rx_we,
  output logic [BI_W-1:0]  rx_idx,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int TOT_W = CNT_W + 1;

  eng_state_t       state;
  logic [DIV_W-1:0] div;
  logic [2:0]       bit_no;
  logic [TOT_W-1:0] byte_no;
  logic [6:0]       rx_sh;
  logic [TOT_W-1:0] total;
  logic             half_end;
  logic             last_byte;
  logic             rx_phase;

  assign total     = TOT_W'(frame_bytes(16'(tx_n), 16'(rx_n)));
  assign half_end  = div == DIV_W'(HALF - 1);
  assign last_byte = byte_no == (total - TOT_W'(1));
  assign rx_phase  = byte_no >= TOT_W'(tx_n);
  assign busy      = state != ST_IDLE;
  assign tx_idx    = byte_no[BI_W-1:0];
  assign mosi      = (state == ST_SHIFT) && !rx_phase && tx_byte[3'd7 - bit_no];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      div     <= '0;
      bit_no  <= '0;
      byte_no <= '0;
      rx_sh   <= '0;
      rx_we   <= 1'b0;
      rx_idx  <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      rx_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go && total != '0) begin
            state   <= ST_SHIFT;
            cs_n    <= 1'b0;
            sck     <= 1'b0;
            div     <= '0;
            bit_no  <= '0;
            byte_no <= '0;
          end
        end
        ST_SHIFT: begin
          if (half_end) begin
            div <= '0;
            sck <= ~sck;
            if (!sck) begin
              rx_sh <= {rx_sh[5:0], miso};
              if (bit_no == 3'd7 && rx_phase) begin
                rx_we   <= 1'b1;
                rx_byte <= {rx_sh, miso};
                rx_idx  <= BI_W'(byte_no - TOT_W'(tx_n));
              end
            end else if (bit_no == 3'd7) begin
              bit_no <= '0;
              if (last_byte) state <= ST_TAIL;
              else           byte_no <= byte_no + TOT_W'(1);
            end else begin
              bit_no <= bit_no + 3'd1;
            end
          end else begin
            div <= div + DIV_W'(1);
          end
        end
        ST_TAIL: begin
          if (div == DIV_W'(CLK_DIV - 1)) begin
            state <= ST_IDLE;
            cs_n  <= 1'b1;
          end else begin
            div <= div + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_bus_bridge.sv
module spi_bus_bridge #(
  parameter int BUF_WORDS = 8,
  parameter int CLK_DIV   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_stb,
  input  logic        bus_we,
  input  logic [8:0]  bus_adr,
  input  logic [15:0] bus_wdat,
  output logic [15:0] bus_rdat,
  output logic        bus_ack,
  output logic        bus_stall,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  localparam int MAX_BYTES = 2 * BUF_WORDS;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int BI_W      = $clog2(MAX_BYTES);

  // internal events, named for the bound checker
  logic             bus_acc;
  logic             go_pulse;
  logic             xfer_busy;
  logic [CNT_W-1:0] tx_n;
  logic [CNT_W-1:0] rx_n;
  logic [BI_W-1:0]  tx_idx;
  logic [7:0]       tx_byte;
  logic             rx_we;
  logic [BI_W-1:0]  rx_idx;
  logic [7:0]       rx_byte;

  spib_regs #(
    .BUF_WORDS(BUF_WORDS),
    .CNT_W    (CNT_W),
    .BI_W     (BI_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .stb    (bus_stb),
    .we     (bus_we),
    .adr    (bus_adr),
    .wdat   (bus_wdat),
    .rdat   (bus_rdat),
    .ack    (bus_ack),
    .stall  (bus_stall),
    .acc    (bus_acc),
    .busy   (xfer_busy),
    .go     (go_pulse),
    .tx_n   (tx_n),
    .rx_n   (rx_n),
    .tx_idx (tx_idx),
    .tx_byte(tx_byte),
    .rx_we  (rx_we),
    .rx_idx (rx_idx),
    .rx_byte(rx_byte)
  );

  spib_engine #(
    .CLK_DIV(CLK_DIV),
    .CNT_W  (CNT_W),
    .BI_W   (BI_W)
  ) u_engine (
    .clk    (clk),
    .rst    (rst),
    .go     (go_pulse),
    .tx_n   (tx_n),
    .rx_n   (rx_n),
    .tx_idx (tx_idx),
    .tx_byte(tx_byte),
    .rx_we  (rx_we),
    .rx_idx (rx_idx),
    .rx_byte(rx_byte),
    .busy   (xfer_busy),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .miso   (spi_miso),
    .cs_n   (spi_cs_n)
  );

endmodule

// File: rtl/spib_chk.sv
module spib_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [8:0]       bus_adr,
  input logic             bus_ack,
  input logic             bus_stall,
  input logic [15:0]      bus_rdat,
  input logic             bus_acc,
  input logic             go_pulse,
  input logic [CNT_W-1:0] tx_n,
  input logic [CNT_W-1:0] rx_n,
  input logic             rx_we,
  input logic             spi_sck,
  input logic             spi_mosi,
  input logic             spi_cs_n
);

  // R8
  ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
    bus_acc |=> bus_ack);

  // R8
  stall_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stall |-> (bus_we && !spi_cs_n));

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R7
  cs_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> $past(go_pulse));

  // R3
  empty_go_chk: assert property (@(posedge clk) disable iff (rst)
    (go_pulse && tx_n == '0 && rx_n == '0) |=> spi_cs_n);

  // R4
  status_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && $past(bus_acc && !bus_we && bus_adr == 9'h102))
      |-> bus_rdat == {16{!$past(spi_cs_n)}});

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sck) |-> $stable(spi_mosi));

  // R6
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    rx_we |-> !spi_cs_n);

endmodule

bind spi_bus_bridge spib_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_adr  (bus_adr),
  .bus_ack  (bus_ack),
  .bus_stall(bus_stall),
  .bus_rdat (bus_rdat),
  .bus_acc  (bus_acc),
  .go_pulse (go_pulse),
  .tx_n     (tx_n),
  .rx_n     (rx_n),
  .rx_we    (rx_we),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n)
);

// File: tb/test_spi_bus_bridge.sv
`timescale 1ns/100ps
module test_spi_bus_bridge;
  localparam int DIV   = 4;
  localparam int WORDS = 8;
  localparam int MAXB  = 2 * WORDS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_stb = 1'b0;
  logic        bus_we = 1'b0;
  logic [8:0]  bus_adr = '0;
  logic [15:0] bus_wdat = '0;
  logic [15:0] bus_rdat;
  logic        bus_ack;
  logic        bus_stall;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;
  logic        spi_cs_n;

  spi_bus_bridge #(.BUF_WORDS(WORDS), .CLK_DIV(DIV)) i_spi_bus_bridge (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack), .bus_stall(bus_stall),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vecs = 0;
  int bad = 0;
  int win_lo = 0;
  int win_hi = 0;
  int tx_set = 0;
  int rx_set = 0;
  int last_acc = 0;
  int seed = 0;
  logic [15:0] bw [WORDS];

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'(seed * 3 + k * 29 + 90);
  endfunction

  function automatic logic [7:0] sent_byte(input int k);
    return k[0] ? bw[k/2][15:8] : bw[k/2][7:0];
  endfunction

  // behavioural SPI device: records MOSI bytes, plays resp() on MISO
  int s_bit = 0;
  int s_byte = 0;
  logic [7:0] s_cur = '0;
  logic [7:0] s_tmp;
  logic [7:0] mq[$];

  always @(negedge spi_cs_n) begin
    s_bit = 0;
    s_byte = 0;
    mq.delete();
    s_tmp = resp(0);
    spi_miso = s_tmp[7];
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    s_cur = {s_cur[6:0], spi_mosi};
    s_bit++;
    if (s_bit == 8) begin
      mq.push_back(s_cur);
      s_bit = 0;
      s_byte++;
    end
  end

  always @(negedge spi_sck) if (!spi_cs_n) begin
    s_tmp = resp(s_byte);
    spi_miso = s_tmp[7 - s_bit];
  end

  // per-clock reference of the chip-select window and stall
  always @(negedge clk) if (!rst) begin
    logic exp_low;
    #1;
    exp_low = (cyc >= win_lo) && (cyc < win_hi);
    chk("R7 cs_n window", int'(spi_cs_n), int'(!exp_low));
    if (!exp_low) chk("R7 sck idle", int'(spi_sck), 0);
    if (bus_stb && bus_we) chk("R8 stall while busy", int'(bus_stall), int'(exp_low));
  end

  task automatic bus(input logic w, input logic [8:0] a, input logic [15:0] d,
                     output logic [15:0] q, output int waits);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = w; bus_adr = a; bus_wdat = d;
    waits = 0;
    #1;
    while (bus_stall) begin
      waits++;
      @(negedge clk);
      #1;
    end
    last_acc = cyc + 1;
    if (w) begin
      if (a == 9'h100) tx_set = (d > MAXB) ? MAXB : int'(d);
      if (a == 9'h101) rx_set = (d > MAXB) ? MAXB : int'(d);
      if (a < WORDS) bw[a] = d;
      if (a == 9'h102) begin
        win_lo = cyc + 1;
        win_hi = (tx_set + rx_set == 0) ? win_lo : win_lo + DIV * (8 * (tx_set + rx_set) + 1);
      end
    end
    @(negedge clk);
    chk("R8 ack one cycle after accept", int'(bus_ack), 1);
    q = bus_rdat;
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    logic [15:0] q;
    int waits;
    bus(1'b1, a, d, q, waits);
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] q);
    int waits;
    bus(1'b0, a, 16'h0, q, waits);
    chk("R8 read not stalled", waits, 0);
  endtask

  task automatic wait_done;
    while (cyc < win_hi) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    #750000;
    bad++;
    $display("FAIL R7 watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] q;
    int waits;
    for (int i = 0; i < WORDS; i++) bw[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 cs_n after reset", int'(spi_cs_n), 1);
    chk("R1 sck after reset", int'(spi_sck), 0);
    rd(9'h102, q); chk("R1 status", int'(q), 0);
    rd(9'h100, q); chk("R1 send count", int'(q), 0);
    rd(9'h101, q); chk("R1 receive count", int'(q), 0);

    // R10 unmapped addresses
    wr(9'h055, 16'h1234);
    rd(9'h055, q); chk("R10 unmapped read", int'(q), 0);
    wr(9'h008, 16'hBEEF);
    rd(9'h000, q); chk("R10 no alias into word 0", int'(q), 0);
    rd(9'h008, q); chk("R10 word past buffer", int'(q), 0);

    // R2 count registers and clamp
    wr(9'h100, 16'd40);
    rd(9'h100, q); chk("R2 send count clamp", int'(q), 16);
    wr(9'h101, 16'd17);
    rd(9'h101, q); chk("R2 receive count clamp", int'(q), 16);
    wr(9'h101, 16'd5);
    rd(9'h101, q); chk("R2 receive count", int'(q), 5);

    // R5 send-only, three bytes
    wr(9'h000, 16'h2211);
    wr(9'h001, 16'h4433);
    wr(9'h100, 16'd3);
    wr(9'h101, 16'd0);
    wr(9'h102, 16'h5A5A);
    rd(9'h102, q); chk("R4 status busy", int'(q), 16'hFFFF);
    wait_done();
    rd(9'h102, q); chk("R4 status idle", int'(q), 0);
    chk("R5 byte count on MOSI", mq.size(), 3);
    if (mq.size() == 3) begin
      chk("R5 first byte low half of word 0", int'(mq[0]), 8'h11);
      chk("R5 second byte high half of word 0", int'(mq[1]), 8'h22);
      chk("R5 third byte low half of word 1", int'(mq[2]), 8'h33);
    end

    // R8 R9 write held off during a transfer
    wr(9'h100, 16'd2);
    wr(9'h102, 16'h0000);
    rd(9'h100, q); chk("R8 read during transfer", int'(q), 2);
    bus(1'b1, 9'h003, 16'h7788, q, waits);
    chk("R9 write held until transfer end", int'(last_acc >= win_hi), 1);
    chk("R9 write was stalled", int'(waits > 0), 1);
    rd(9'h003, q); chk("R9 held write applied", int'(q), 16'h7788);

    // R6 mixed: four sent, five received
    for (int i = 0; i < WORDS; i++) wr(9'(i), 16'(i * 16'h1111 + 16'h0102));
    seed = 7;
    wr(9'h100, 16'd4);
    wr(9'h101, 16'd5);
    wr(9'h102, 16'h1);
    wait_done();
    chk("R6 bytes framed", mq.size(), 9);
    if (mq.size() == 9) begin
      for (int k = 0; k < 4; k++) chk("R5 sent byte", int'(mq[k]), int'(sent_byte(k)));
      for (int k = 4; k < 9; k++) chk("R6 MOSI zero while receiving", int'(mq[k]), 0);
    end
    rd(9'h000, q); chk("R6 word 0", int'(q), int'({resp(5), resp(4)}));
    rd(9'h001, q); chk("R6 word 1", int'(q), int'({resp(7), resp(6)}));
    rd(9'h002, q); chk("R6 odd last byte low half", int'(q[7:0]), int'(resp(8)));
    rd(9'h003, q); chk("R6 word past data untouched", int'(q), int'(bw[3]));

    // R6 receive only
    seed = 3;
    wr(9'h100, 16'd0);
    wr(9'h101, 16'd2);
    wr(9'h102, 16'h1);
    wait_done();
    chk("R6 receive-only count", mq.size(), 2);
    if (mq.size() == 2) chk("R6 receive-only MOSI zero", int'(mq[0]) + int'(mq[1]), 0);
    rd(9'h000, q); chk("R6 receive-only word 0", int'(q), int'({resp(1), resp(0)}));

    // R3 empty transfer
    wr(9'h101, 16'd0);
    wr(9'h102, 16'hFFFF);
    rd(9'h102, q); chk("R3 empty go stays idle", int'(q), 0);
    chk("R3 cs_n stays high", int'(spi_cs_n), 1);

    // R2 R7 clamped maximum in both directions
    for (int i = 0; i < WORDS; i++) wr(9'(i), 16'(16'hA000 + i * 16'h0305));
    seed = 11;
    wr(9'h100, 16'd20);
    wr(9'h101, 16'd99);
    rd(9'h100, q); chk("R2 send count clamp again", int'(q), 16);
    wr(9'h102, 16'h1);
    wait_done();
    chk("R7 full frame byte count", mq.size(), 32);
    if (mq.size() == 32)
      for (int k = 0; k < 16; k++) chk("R5 full frame sent byte", int'(mq[k]), int'(sent_byte(k)));
    for (int i = 0; i < WORDS; i++) begin
      rd(9'(i), q);
      chk("R6 full frame word", int'(q), int'({resp(16 + 2 * i + 1), resp(16 + 2 * i)}));
    end

    summary();
    $finish;
  end

endmodule